// File: doc/BRIEF.md
# PWM Crest/Trough Interrupt Decimator

This block sits beside a triangle-wave (up/down counting) PWM timer and reduces how often its periodic interrupts reach the CPU. The timer delivers a single-cycle event pulse when the carrier reaches its peak (crest) and another when it reaches its valley (trough). Each of these two sources has its own 3-bit skip count N and its own enable. While a source is enabled, only one event in every N+1 is passed on. Every other event is dropped.

The same pass/drop decision can also be applied to two companion strobes per source. The first is the request that moves buffered values into the compare registers. The second is the delayed A/D converter start request. With these links on, register reloads and conversions follow the interrupt rate that has been thinned out. A bypass bit turns the thinning off for both sources.

Software programs the block through a small write/read register port. Writes to a source's skip field are refused while that source's interrupt is enabled or a compare match is in progress. A new count value is taken only while the source is disabled.

Top module: `pwm_evt_decimator`

## Requirements
- R1: After reset all outputs are 0, and both register addresses read back 0.
- R2: While a source's enable is 0, every one of its events is passed and its skip counter is held at 0.
- R3: With the source enabled and skip count N, the events numbered N+1, 2N+2, 3N+3, … (counting from 1 after enabling) are passed, and all other events are dropped.
- R4: With the source enabled and N = 0, every event is passed. With N = 7, one event in eight is passed.
- R5: Writing a source's enable to 0 resets its counter. After it is re-enabled, counting restarts from the first event. A new count value is accepted only while the stored enable is 0.
- R6: The crest and trough decimators run independently. Each uses its own count and its own enable.
- R7: When the bypass bit (address 1, bit 0) is 1, every event from both sources passes, whatever the enables and counts are.
- R8: Every output is registered. It is high for exactly the one cycle that follows the input pulse that caused it.
- R9: The transfer-link bit (address 1, bit 1) controls the transfer strobes. When it is 1, a transfer strobe passes only if the most recent event of its source passed. When it is 0, transfer strobes pass unchanged.
- R10: The A/D-link bit (address 1, bit 2) gates the A/D strobes in the same way, using the most recent decision of their source.
- R11: A write to a source's field at address 0 is ignored in three cases: the source's interrupt enable input is high, cmp_match_i is high, or the write changes the count while the source is enabled. The fields of the other source are still written.
- R12: Address 0 reads back as {trough_en[7], trough_cnt[6:4], crest_en[3], crest_cnt[2:0]}. Address 1 reads back as {0[7:3], adc_link[2], xfer_link[1], bypass[0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register address (0 = skip, 1 = control) |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i |
| crest_irq_en_i | input | 1 | Crest interrupt enabled; blocks writes to the crest field |
| trough_irq_en_i | input | 1 | Trough interrupt enabled; blocks writes to the trough field |
| cmp_match_i | input | 1 | Compare match in progress; blocks writes to the skip fields |
| crest_evt_i | input | 1 | Crest event pulse |
| trough_evt_i | input | 1 | Trough event pulse |
| crest_xfer_i | input | 1 | Crest buffer-transfer request |
| trough_xfer_i | input | 1 | Trough buffer-transfer request |
| crest_adc_i | input | 1 | Delayed crest A/D start request |
| trough_adc_i | input | 1 | Delayed trough A/D start request |
| crest_irq_o | output | 1 | Decimated crest interrupt |
| trough_irq_o | output | 1 | Decimated trough interrupt |
| crest_xfer_o | output | 1 | Gated crest transfer strobe |
| trough_xfer_o | output | 1 | Gated trough transfer strobe |
| crest_adc_o | output | 1 | Gated crest A/D strobe |
| trough_adc_o | output | 1 | Gated trough A/D strobe |

## Verification
The hardest state to reach is a counter that is part-way through its cycle at the moment its enable is cleared. If the clear failed, the fault would show only as an early pass several events later. The stimulus enables a source with N = 3 and sends two events, so the counter stands at 2. It then disables and re-enables the source and expects the pass on the fourth event, not the second. The write-guard cases are tested in a similar way. The bench writes under each blocking condition, reads the register back, and then checks that the event pattern still follows the old count.

// File: rtl/pwm_dec_pkg.sv
package pwm_dec_pkg;
  localparam int NUM_SRC    = 2;
  localparam int SRC_CREST  = 0;
  localparam int SRC_TROUGH = 1;

  localparam logic ADDR_SKIP = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int CTRL_BYPASS = 0;
  localparam int CTRL_XFER   = 1;
  localparam int CTRL_ADC    = 2;
endpackage

// File: rtl/pwm_dec_regs.sv
module pwm_dec_regs
  import pwm_dec_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic                            addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [NUM_SRC-1:0]              irq_en_i,
  input  logic                            cmp_match_i,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0][CNT_W-1:0]   lim_o,
  output logic                            bypass_o,
  output logic                            xfer_link_o,
  output logic                            adc_link_o
);
  localparam int FLD_W = CNT_W + 1;

  logic [NUM_SRC-1:0]            en_q;
  logic [NUM_SRC-1:0][CNT_W-1:0] lim_q;
  logic                          bypass_q, xfer_q, adc_q;
  logic                          skip_wr, ctrl_wr;
  logic [NUM_SRC-1:0]            fld_ok;

  assign skip_wr = we_i && (addr_i == ADDR_SKIP);
  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      fld_ok[s] = skip_wr && !irq_en_i[s] && !cmp_match_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lim_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (fld_ok[s]) begin
          en_q[s] <= wdata_i[s*FLD_W + CNT_W];
          // count is frozen while the source runs
          if (!en_q[s]) lim_q[s] <= wdata_i[s*FLD_W +: CNT_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b0;
      xfer_q   <= 1'b0;
      adc_q    <= 1'b0;
    end else if (ctrl_wr) begin
      bypass_q <= wdata_i[CTRL_BYPASS];
      xfer_q   <= wdata_i[CTRL_XFER];
      adc_q    <= wdata_i[CTRL_ADC];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_SKIP) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        rdata_o[s*FLD_W +: CNT_W]   = lim_q[s];
        rdata_o[s*FLD_W + CNT_W]    = en_q[s];
      end
    end else begin
      rdata_o[CTRL_BYPASS] = bypass_q;
      rdata_o[CTRL_XFER]   = xfer_q;
      rdata_o[CTRL_ADC]    = adc_q;
    end
  end

  assign en_o        = en_q;
  assign lim_o       = lim_q;
  assign bypass_o    = bypass_q;
  assign xfer_link_o = xfer_q;
  assign adc_link_o  = adc_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    AST_SKIP_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(skip_wr && (irq_en_i[g] || cmp_match_i)) |-> ($stable(lim_q[g]) && $stable(en_q[g]))); // R11
    AST_LIM_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_q[g]) |-> $stable(lim_q[g])); // R5
  end
endmodule

// File: rtl/pwm_dec_skip_ctr.sv
module pwm_dec_skip_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             pass_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active, hit;

  assign active = en_i && !bypass_i;
  assign hit    = (cnt_q == lim_i);
  assign pass_o = !active || hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_WITHIN_LIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cnt_q <= lim_i)); // R3
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!active) |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/pwm_dec_gate.sv
module pwm_dec_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic pass_i,
  input  logic xfer_i,
  input  logic adc_i,
  input  logic xfer_link_i,
  input  logic adc_link_i,
  output logic irq_o,
  output logic xfer_o,
  output logic adc_o
);
  logic last_q, cur_pass;
  logic irq_q, xfer_q, adc_q;

  // decision of the newest event, held for strobes that trail it
  assign cur_pass = evt_i ? pass_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b1;
      irq_q  <= 1'b0;
      xfer_q <= 1'b0;
      adc_q  <= 1'b0;
    end else begin
      last_q <= cur_pass;
      irq_q  <= evt_i && pass_i;
      xfer_q <= xfer_i && (!xfer_link_i || cur_pass);
      adc_q  <= adc_i && (!adc_link_i || cur_pass);
    end
  end

  assign irq_o  = irq_q;
  assign xfer_o = xfer_q;
  assign adc_o  = adc_q;

  AST_IRQ_FROM_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(evt_i)); // R8
  AST_XFER_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $past(xfer_i)); // R9
  AST_XFER_UNLINKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(xfer_i && !xfer_link_i) |-> xfer_o); // R9
  AST_ADC_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_o |-> $past(adc_i)); // R10
endmodule

// File: rtl/pwm_evt_decimator.sv
module pwm_evt_decimator
  import pwm_dec_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              crest_irq_en_i,
  input  logic              trough_irq_en_i,
  input  logic              cmp_match_i,
  input  logic              crest_evt_i,
  input  logic              trough_evt_i,
  input  logic              crest_xfer_i,
  input  logic              trough_xfer_i,
  input  logic              crest_adc_i,
  input  logic              trough_adc_i,
  output logic              crest_irq_o,
  output logic              trough_irq_o,
  output logic              crest_xfer_o,
  output logic              trough_xfer_o,
  output logic              crest_adc_o,
  output logic              trough_adc_o
);
  logic [NUM_SRC-1:0]            irq_en, evt, xfer_req, adc_req;
  logic [NUM_SRC-1:0]            irq, xfer, adc, pass, en;
  logic [NUM_SRC-1:0][CNT_W-1:0] lim;
  logic                          bypass, xfer_link, adc_link;

  assign irq_en   = {trough_irq_en_i, crest_irq_en_i};
  assign evt      = {trough_evt_i,    crest_evt_i};
  assign xfer_req = {trough_xfer_i,   crest_xfer_i};
  assign adc_req  = {trough_adc_i,    crest_adc_i};

  pwm_dec_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .irq_en_i    (irq_en),
    .cmp_match_i (cmp_match_i),
    .en_o        (en),
    .lim_o       (lim),
    .bypass_o    (bypass),
    .xfer_link_o (xfer_link),
    .adc_link_o  (adc_link)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pwm_dec_skip_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en[g]),
      .bypass_i (bypass),
      .evt_i    (evt[g]),
      .lim_i    (lim[g]),
      .pass_o   (pass[g])
    );

    pwm_dec_gate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_i       (evt[g]),
      .pass_i      (pass[g]),
      .xfer_i      (xfer_req[g]),
      .adc_i       (adc_req[g]),
      .xfer_link_i (xfer_link),
      .adc_link_i  (adc_link),
      .irq_o       (irq[g]),
      .xfer_o      (xfer[g]),
      .adc_o       (adc[g])
    );

    AST_BYPASS_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(bypass && evt[g]) |-> irq[g]); // R7
  end

  assign crest_irq_o   = irq[SRC_CREST];
  assign trough_irq_o  = irq[SRC_TROUGH];
  assign crest_xfer_o  = xfer[SRC_CREST];
  assign trough_xfer_o = xfer[SRC_TROUGH];
  assign crest_adc_o   = adc[SRC_CREST];
  assign trough_adc_o  = adc[SRC_TROUGH];
endmodule

// File: tb/pwm_evt_decimator_tb.sv
module pwm_evt_decimator_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic c_ien = 1'b0, t_ien = 1'b0, cmp = 1'b0;
  logic c_evt = 1'b0, t_evt = 1'b0, c_xf = 1'b0, t_xf = 1'b0, c_ad = 1'b0, t_ad = 1'b0;
  logic c_irq, t_irq, c_xfo, t_xfo, c_ado, t_ado;
  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_evt_decimator dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .crest_irq_en_i(c_ien), .trough_irq_en_i(t_ien), .cmp_match_i(cmp),
    .crest_evt_i(c_evt), .trough_evt_i(t_evt),
    .crest_xfer_i(c_xf), .trough_xfer_i(t_xf),
    .crest_adc_i(c_ad), .trough_adc_i(t_ad),
    .crest_irq_o(c_irq), .trough_irq_o(t_irq),
    .crest_xfer_o(c_xfo), .trough_xfer_o(t_xfo),
    .crest_adc_o(c_ado), .trough_adc_o(t_ado)
  );

  // {skip, ctrl, crest pass mask, trough pass mask} over 16 events
  localparam logic [47:0] VEC [7] = '{
    {8'h00, 8'h00, 16'hFFFF, 16'hFFFF},
    {8'hFA, 8'h06, 16'h4924, 16'h8080},
    {8'hB8, 8'h00, 16'hFFFF, 16'h8888},
    {8'h0D, 8'h02, 16'h0820, 16'hFFFF},
    {8'hFF, 8'h07, 16'hFFFF, 16'hFFFF},
    {8'hE9, 8'h02, 16'hAAAA, 16'h2040},
    {8'h9C, 8'h04, 16'h4210, 16'hAAAA}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  // one event on both sources with coincident transfer, A/D one cycle later
  task automatic evt_both(output logic ci, output logic ti, output logic cx,
                          output logic tx, output logic ca, output logic ta);
    @(negedge clk); c_evt = 1'b1; t_evt = 1'b1; c_xf = 1'b1; t_xf = 1'b1;
    @(negedge clk); ci = c_irq; ti = t_irq; cx = c_xfo; tx = t_xfo;
    c_evt = 1'b0; t_evt = 1'b0; c_xf = 1'b0; t_xf = 1'b0; c_ad = 1'b1; t_ad = 1'b1;
    @(negedge clk); ca = c_ado; ta = t_ado; c_ad = 1'b0; t_ad = 1'b0;
  endtask

  task automatic evt_crest(output logic ci, output logic ci_next);
    @(negedge clk); c_evt = 1'b1;
    @(negedge clk); ci = c_irq; c_evt = 1'b0;
    @(negedge clk); ci_next = c_irq;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <= 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic ci, ti, cx, tx, ca, ta, cn;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 outputs", 32'({c_irq, t_irq, c_xfo, t_xfo, c_ado, t_ado}), 32'h0);
    rd(1'b0, 8'h00, "R1 R12 skip reg");
    rd(1'b1, 8'h00, "R1 R12 ctrl reg");

    // vector walk: R2 R3 R4 R6 R7 R9 R10 R12
    for (int v = 0; v < 7; v++) begin
      wr(1'b0, 8'h00);
      wr(1'b1, VEC[v][39:32]);
      wr(1'b0, VEC[v][47:40]);
      rd(1'b0, VEC[v][47:40], "R12 skip readback");
      rd(1'b1, VEC[v][39:32], "R12 ctrl readback");
      for (int i = 0; i < 16; i++) begin
        logic cm, tm, xl, al;
        cm = VEC[v][16+i]; tm = VEC[v][i];
        xl = VEC[v][33]; al = VEC[v][34];
        evt_both(ci, ti, cx, tx, ca, ta);
        chk($sformatf("R3 R4 R6 R7 crest irq v%0d e%0d", v, i), 32'(ci), 32'(cm));
        chk($sformatf("R3 R4 R6 R7 trough irq v%0d e%0d", v, i), 32'(ti), 32'(tm));
        chk($sformatf("R9 crest xfer v%0d e%0d", v, i), 32'(cx), 32'(xl ? cm : 1'b1));
        chk($sformatf("R9 trough xfer v%0d e%0d", v, i), 32'(tx), 32'(xl ? tm : 1'b1));
        chk($sformatf("R10 crest adc v%0d e%0d", v, i), 32'(ca), 32'(al ? cm : 1'b1));
        chk($sformatf("R10 trough adc v%0d e%0d", v, i), 32'(ta), 32'(al ? tm : 1'b1));
      end
    end

    // R8 single-cycle pulse, N=0 enabled
    wr(1'b1, 8'h00); wr(1'b0, 8'h00); wr(1'b0, 8'h08);
    evt_crest(ci, cn);
    chk("R8 pulse high", 32'(ci), 32'h1);
    chk("R8 pulse one cycle", 32'(cn), 32'h0);

    // R5 clear enable mid-count, N=3
    wr(1'b0, 8'h03); wr(1'b0, 8'h0B);
    evt_crest(ci, cn); chk("R5 pre e1", 32'(ci), 32'h0);
    evt_crest(ci, cn); chk("R5 pre e2", 32'(ci), 32'h0);
    wr(1'b0, 8'h03); wr(1'b0, 8'h0B);
    for (int i = 0; i < 4; i++) begin
      evt_crest(ci, cn);
      chk($sformatf("R5 restart e%0d", i), 32'(ci), 32'(i == 3));
    end

    // R11 blocked writes
    wr(1'b0, 8'h03); wr(1'b0, 8'h0B);
    c_ien = 1'b1; wr(1'b0, 8'h00); c_ien = 1'b0;
    rd(1'b0, 8'h0B, "R11 irq enable blocks");
    cmp = 1'b1; wr(1'b0, 8'h00); cmp = 1'b0;
    rd(1'b0, 8'h0B, "R11 compare match blocks");
    wr(1'b0, 8'h09);
    rd(1'b0, 8'h0B, "R11 R5 count locked while enabled");
    c_ien = 1'b1; wr(1'b0, 8'h50); c_ien = 1'b0;
    rd(1'b0, 8'h5B, "R11 other field still written");
    for (int i = 0; i < 4; i++) begin
      evt_both(ci, ti, cx, tx, ca, ta);
      chk($sformatf("R11 crest keeps N3 e%0d", i), 32'(ci), 32'(i == 3));
      chk($sformatf("R11 R2 trough disabled e%0d", i), 32'(ti), 32'h1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule